// File: doc/BRIEF.md
# Beacon Timestamp Receiver Synchronizer

This block watches a demodulated serial bitstream for the start of a beacon. A beacon opens with a long preamble of alternating ones and zeros. When the block has seen enough consecutive alternating bits, it treats the next 64 valid bits as the sender's clock value, most significant bit first. It adds a programmable delay correction to that value and writes the sum into a local hop timer. From then on the timer counts in step with the sender.

Input bits arrive as a data bit with a qualifier. Cycles without the qualifier are gaps, and they do not count as bits. While the timestamp is being collected, a gap longer than a programmable limit drops the partial value and sends the block back to searching. The outputs are the running time, a flag that stays high from the last successful load until the next preamble is recognised, and a one-cycle pulse on each load.

Top module: `beacon_sync_rx`

## Requirements
- R1: After reset, `local_time` is 0, `locked` is 0 and `load_pulse` is 0.
- R2: The preamble is recognised on the valid bit that completes a run of SYNC_LEN (80 by default) consecutive valid bits, each differing from the one before. A valid bit equal to its predecessor starts a new run of length one. No assumption is made about the polarity of the first bit.
- R3: Cycles with `bit_vld` low are ignored. They neither break a preamble run nor add a bit to the timestamp, provided a timestamp gap does not exceed the limit in R9.
- R4: The TS_W (64) valid bits that follow the recognising bit form the timestamp. The first of them is bit TS_W-1.
- R5: On a load, `local_time` becomes timestamp + `dly_ofs` (offset zero-extended), plus 1 if `tick_en` is high in that cycle. The sum wraps modulo 2^TS_W.
- R6: `load_pulse` is high for exactly the one cycle after the edge that samples the last timestamp bit, and it is low at all other times.
- R7: Outside a load, `local_time` increases by one at each clock edge where `tick_en` is high and holds otherwise.
- R8: `locked` rises with the load and stays high until reset or until the next preamble is recognised, when it falls.
- R9: While the timestamp is being collected, more than `idle_limit` consecutive cycles without `bit_vld` discard the capture and no load happens. A gap of exactly `idle_limit` cycles is tolerated.
- R10: After a load or an abort, the preamble search starts from an empty run, so bits received before that point never count toward the next preamble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timer count enable |
| bit_in | input | 1 | Demodulated data bit |
| bit_vld | input | 1 | Qualifies `bit_in` in this cycle |
| dly_ofs | input | OFS_W (16) | Propagation-delay correction added on load |
| idle_limit | input | TMO_W (8) | Largest tolerated gap during timestamp capture, in cycles |
| local_time | output | TS_W (64) | Running local hop time |
| locked | output | 1 | Timer aligned to the last received beacon |
| load_pulse | output | 1 | One-cycle pulse when the timer is written |

## Verification
Some properties are checked by assertions on every cycle:
- the timer steps by exactly one on non-load ticks;
- a load pulse is a single cycle and always comes with the lock flag;
- the preamble run count holds through invalid cycles;
- an abort happens only during capture gaps, and a completed capture and an abort never coincide.

Other behaviour depends on whole bit sequences, so only the bench scenarios can show it. These include the exact arithmetic of the loaded value, MSB-first field order and wraparound. They also include the run restart on a repeated bit, the clearing of the run after a load, and the boundary between a gap of exactly the limit and one cycle longer.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
   typedef enum logic {
      ST_HUNT  = 1'b0,
      ST_STAMP = 1'b1
   } bsr_state_e;
endpackage

// File: rtl/bsr_preamble.sv
// Alternating-run detector: flags the bit that completes SYNC_LEN toggles.
module bsr_preamble #(
   parameter int SYNC_LEN = 80
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic bit_in,
   input  logic bit_vld,
   output logic hit
);
   localparam int CW = $clog2(SYNC_LEN + 1);
   localparam logic [CW-1:0] LAST = CW'(SYNC_LEN - 1);

   if (SYNC_LEN < 2) begin : g_chk_len
      $error("bsr_preamble: SYNC_LEN must be at least 2");
   end

   logic [CW-1:0] run_q;
   logic          prev_q;
   logic          toggles;

   assign toggles = (run_q == '0) || (bit_in != prev_q);
   assign hit     = en && bit_vld && toggles && (run_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q  <= '0;
         prev_q <= 1'b0;
      end else if (!en) begin
         run_q  <= '0;
      end else if (bit_vld) begin
         prev_q <= bit_in;
         if (!toggles)
            run_q <= CW'(1);
         else if (run_q == LAST)
            run_q <= '0;
         else
            run_q <= run_q + CW'(1);
      end
   end

   // R3: gaps leave the run untouched while searching
   assert_gap_holds_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !bit_vld) |=> (run_q == $past(run_q)));

   // R2: run count never passes the recognition point
   assert_run_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= LAST);
endmodule

// File: rtl/bsr_stamp.sv
// Timestamp shifter with gap timeout; owns the hunt/capture state.
module bsr_stamp
   import bsr_pkg::*;
#(
   parameter int TS_W  = 64,
   parameter int TMO_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit,
   input  logic             bit_in,
   input  logic             bit_vld,
   input  logic [TMO_W-1:0] idle_limit,
   output logic             hunting,
   output logic             done,
   output logic             abort,
   output logic [TS_W-1:0]  word
);
   localparam int BW = $clog2(TS_W);
   localparam logic [BW-1:0] LAST_BIT = BW'(TS_W - 1);

   if (TS_W < 2) begin : g_chk_w
      $error("bsr_stamp: TS_W must be at least 2");
   end
   if (TMO_W < 1) begin : g_chk_t
      $error("bsr_stamp: TMO_W must be at least 1");
   end

   bsr_state_e       state_q;
   logic [BW-1:0]    bcnt_q;
   logic [TS_W-1:0]  sreg_q;
   logic [TMO_W-1:0] idle_q;

   assign hunting = (state_q == ST_HUNT);
   assign done    = (state_q == ST_STAMP) && bit_vld && (bcnt_q == LAST_BIT);
   assign abort   = (state_q == ST_STAMP) && !bit_vld && (idle_q == idle_limit);
   assign word    = {sreg_q[TS_W-2:0], bit_in};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_HUNT;
         bcnt_q  <= '0;
         sreg_q  <= '0;
         idle_q  <= '0;
      end else begin
         case (state_q)
            ST_HUNT: begin
               if (hit) begin
                  state_q <= ST_STAMP;
                  bcnt_q  <= '0;
                  idle_q  <= '0;
               end
            end
            default: begin
               if (bit_vld) begin
                  sreg_q <= word;
                  bcnt_q <= bcnt_q + BW'(1);
                  idle_q <= '0;
                  if (done) state_q <= ST_HUNT;
               end else if (abort) begin
                  state_q <= ST_HUNT;
               end else begin
                  idle_q <= idle_q + TMO_W'(1);
               end
            end
         endcase
      end
   end

   // R9: abort only inside a capture gap
   assert_abort_in_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      abort |-> (!bit_vld && !hunting));

   // R9: completion and abort are exclusive
   assert_done_not_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && abort));

   // R10: search resumes after a completed capture
   assert_done_rehunt_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done || abort) |=> hunting);
endmodule

// File: rtl/bsr_timer.sv
// Local hop timer: loads corrected timestamp, otherwise counts enables.
module bsr_timer #(
   parameter int TS_W       = 64,
   parameter int OFS_W      = 16,
   parameter bit SIGNED_OFS = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             load_en,
   input  logic [TS_W-1:0]  load_word,
   input  logic [OFS_W-1:0] ofs,
   input  logic             clear_lock,
   output logic [TS_W-1:0]  time_q,
   output logic             locked_q,
   output logic             pulse_q
);
   if (OFS_W < 1 || OFS_W > TS_W) begin : g_chk_ofs
      $error("bsr_timer: OFS_W must lie in 1..TS_W");
   end

   logic [TS_W-1:0] ofs_ext;
   logic [TS_W-1:0] load_val;

   if (OFS_W == TS_W) begin : g_ofs_full
      assign ofs_ext = ofs;
   end else if (SIGNED_OFS) begin : g_ofs_sext
      assign ofs_ext = {{(TS_W-OFS_W){ofs[OFS_W-1]}}, ofs};
   end else begin : g_ofs_zext
      assign ofs_ext = {{(TS_W-OFS_W){1'b0}}, ofs};
   end

   assign load_val = load_word + ofs_ext + TS_W'(tick_en);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         time_q   <= '0;
         locked_q <= 1'b0;
         pulse_q  <= 1'b0;
      end else begin
         pulse_q <= load_en;
         if (load_en)       time_q <= load_val;
         else if (tick_en)  time_q <= time_q + TS_W'(1);
         if (load_en)         locked_q <= 1'b1;
         else if (clear_lock) locked_q <= 1'b0;
      end
   end

   // R7: a non-load tick advances by exactly one
   assert_step_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_en && tick_en) |=> (time_q == $past(time_q) + TS_W'(1)));

   // R7: no tick and no load keeps the time
   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_en && !tick_en) |=> $stable(time_q));

   // R6: the load pulse lasts one cycle
   assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |=> !pulse_q);

   // R8: a load always leaves the lock flag set
   assert_pulse_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |-> locked_q);
endmodule

// File: rtl/beacon_sync_rx.sv
module beacon_sync_rx #(
   parameter int SYNC_LEN   = 80,
   parameter int TS_W       = 64,
   parameter int OFS_W      = 16,
   parameter int TMO_W      = 8,
   parameter bit SIGNED_OFS = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             bit_in,
   input  logic             bit_vld,
   input  logic [OFS_W-1:0] dly_ofs,
   input  logic [TMO_W-1:0] idle_limit,
   output logic [TS_W-1:0]  local_time,
   output logic             locked,
   output logic             load_pulse
);
   logic            hunting;
   logic            sync_hit;
   logic            cap_done;
   logic            cap_abort;
   logic [TS_W-1:0] cap_word;

   bsr_preamble #(.SYNC_LEN(SYNC_LEN)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (hunting),
      .bit_in  (bit_in),
      .bit_vld (bit_vld),
      .hit     (sync_hit)
   );

   bsr_stamp #(.TS_W(TS_W), .TMO_W(TMO_W)) u_stamp (
      .clk        (clk),
      .rst_n      (rst_n),
      .hit        (sync_hit),
      .bit_in     (bit_in),
      .bit_vld    (bit_vld),
      .idle_limit (idle_limit),
      .hunting    (hunting),
      .done       (cap_done),
      .abort      (cap_abort),
      .word       (cap_word)
   );

   bsr_timer #(.TS_W(TS_W), .OFS_W(OFS_W), .SIGNED_OFS(SIGNED_OFS)) u_tmr (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_en    (tick_en),
      .load_en    (cap_done),
      .load_word  (cap_word),
      .ofs        (dly_ofs),
      .clear_lock (sync_hit),
      .time_q     (local_time),
      .locked_q   (locked),
      .pulse_q    (load_pulse)
   );

   // R8: recognising a preamble drops the lock on the next cycle
   assert_hit_unlocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sync_hit |=> !locked);

   // R9: an abort never produces a load
   assert_abort_no_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cap_abort |=> !load_pulse);
endmodule

// File: tb/sim_beacon_sync_rx.sv
module sim_beacon_sync_rx;
   localparam int TS_W = 64;
   localparam int LIM  = 6;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            tick_en = 1'b0;
   logic            bit_in = 1'b0;
   logic            bit_vld = 1'b0;
   logic [15:0]     dly_ofs = '0;
   logic [7:0]      idle_limit = 8'(LIM);
   logic [TS_W-1:0] local_time;
   logic            locked;
   logic            load_pulse;

   int n_chk = 0;
   int n_bad = 0;
   int pulses = 0;

   always #2.5 clk = ~clk;

   beacon_sync_rx u0 (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bit_in(bit_in),
      .bit_vld(bit_vld), .dly_ofs(dly_ofs), .idle_limit(idle_limit),
      .local_time(local_time), .locked(locked), .load_pulse(load_pulse)
   );

   always @(negedge clk) if (rst_n && load_pulse) pulses++;

   function automatic logic [TS_W-1:0] exp_load(input logic [TS_W-1:0] ts,
                                                input logic [15:0] ofs,
                                                input logic tick);
      return ts + {48'd0, ofs} + TS_W'(tick);
   endfunction

   task automatic chk(input string req, input logic [TS_W-1:0] act,
                      input logic [TS_W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic put_bit(input logic b, input int gap);
      for (int g = 0; g < gap; g++) begin
         bit_vld = 1'b0;
         @(negedge clk);
      end
      bit_in  = b;
      bit_vld = 1'b1;
      @(negedge clk);
      bit_vld = 1'b0;
   endtask

   task automatic send_pre(input int n, input logic first, input int maxgap);
      for (int i = 0; i < n; i++)
         put_bit(first ^ logic'(i[0]), (maxgap > 0) ? int'($urandom_range(0, maxgap)) : 0);
   endtask

   // sends bits TS_W-1 down to lo
   task automatic send_ts(input logic [TS_W-1:0] ts, input int lo, input int maxgap);
      for (int i = TS_W - 1; i >= lo; i--)
         put_bit(ts[i], (maxgap > 0) ? int'($urandom_range(0, maxgap)) : 0);
   endtask

   logic [TS_W-1:0] ts, t0, e;
   int cnt, p0;

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 time", local_time, '0);
      chk("R1 locked", TS_W'(locked), '0);
      chk("R1 pulse", TS_W'(load_pulse), '0);

      // directed beacon
      tick_en = 1'b1; dly_ofs = 16'd5;
      ts = 64'h0123_4567_89AB_CDEF;
      send_pre(80, 1'b0, 0);
      send_ts(ts, 1, 0);
      chk("R6 no early pulse", TS_W'(load_pulse), '0);
      put_bit(ts[0], 0);
      chk("R6 pulse", TS_W'(load_pulse), 1);
      chk("R4 R5 loaded value", local_time, exp_load(ts, 16'd5, 1'b1));
      chk("R8 locked", TS_W'(locked), 1);
      @(negedge clk);
      chk("R6 pulse drops", TS_W'(load_pulse), '0);
      chk("R7 step after load", local_time, exp_load(ts, 16'd5, 1'b1) + 1);

      // R7 random ticks
      t0 = local_time; cnt = 0;
      for (int i = 0; i < 50; i++) begin
         tick_en = 1'($urandom_range(0, 1));
         cnt += int'(tick_en);
         @(negedge clk);
      end
      chk("R7 counted ticks", local_time, t0 + TS_W'(cnt));
      tick_en = 1'b1;

      // R8 noise keeps lock
      for (int i = 0; i < 30; i++) put_bit(1'b1, 0);
      chk("R8 lock through noise", TS_W'(locked), 1);

      // R10: ts tail alternates into next preamble
      ts = 64'hFEDC_BA98_7654_5555;
      send_pre(80, 1'b1, 0);
      send_ts(ts, 0, 0);
      chk("R5 second load", local_time, exp_load(ts, 16'd5, 1'b1));
      ts = 64'h1111_2222_3333_4444;
      send_pre(80, 1'b0, 0);
      chk("R8 lock falls at preamble", TS_W'(locked), '0);
      send_ts(ts, 0, 0);
      chk("R10 run cleared after load", local_time, exp_load(ts, 16'd5, 1'b1));

      // R2 run restart on repeated bit
      send_pre(79, 1'b1, 0);
      ts = 64'hA5A5_0F0F_C3C3_9999;
      send_pre(80, 1'b1, 0);
      send_ts(ts, 0, 0);
      chk("R2 restart on equal bits", local_time, exp_load(ts, 16'd5, 1'b1));

      // R9 abort on gap of LIM+1
      ts = 64'h7777_8888_9999_AAAA;
      send_pre(80, 1'b0, 0);
      send_ts(ts, 44, 0);
      for (int g = 0; g < LIM + 1; g++) @(negedge clk);
      p0 = pulses;
      send_ts(ts << 20, 44, 0);
      chk("R9 no load after abort", TS_W'(pulses - p0), '0);
      chk("R9 unlocked after abort", TS_W'(locked), '0);

      // R9 gap of exactly LIM tolerated; R3 gaps ignored
      put_bit(1'b0, 0);
      ts = 64'h0BAD_F00D_1234_5678;
      dly_ofs = 16'hFFFF;
      send_pre(80, 1'b0, 0);
      send_ts(ts, 30, 0);
      put_bit(ts[29], LIM);
      send_ts(ts << 35, 35, 0);
      chk("R9 exact gap tolerated", local_time, exp_load(ts, 16'hFFFF, 1'b1));

      // R5 wraparound
      ts = '1; dly_ofs = 16'd2;
      send_pre(80, 1'b1, 0);
      send_ts(ts, 0, 0);
      chk("R5 wrap", local_time, 64'd2);

      // R5 no tick in load cycle
      tick_en = 1'b0;
      ts = 64'h0000_0001_0000_0000; dly_ofs = 16'h1234;
      send_pre(80, 1'b0, 0);
      send_ts(ts, 0, 0);
      chk("R5 load without tick", local_time, exp_load(ts, 16'h1234, 1'b0));
      @(negedge clk);
      chk("R7 hold without tick", local_time, exp_load(ts, 16'h1234, 1'b0));

      // random beacons with gaps (R3, R4, R5)
      for (int k = 0; k < 8; k++) begin
         ts = {$urandom, $urandom};
         dly_ofs = 16'($urandom);
         tick_en = 1'($urandom_range(0, 1));
         send_pre(80, 1'($urandom_range(0, 1)), LIM);
         send_ts(ts, 0, LIM);
         e = exp_load(ts, dly_ofs, tick_en);
         chk("R3 R5 random beacon", local_time, e);
         chk("R6 random pulse", TS_W'(load_pulse), 1);
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule